// File: doc/BRIEF.md
# Quad-I/O Flash Read Sequencer

This block sits on the host side of a serial NOR flash and turns byte-read requests into quad-I/O fast-read transactions. A request carries a 24-bit start address and a byte count. The block then runs chip select, the serial clock and four data lines, each line with its own output enable. It returns the fetched bytes one at a time on a valid/ready stream. Each serial clock takes two system cycles: a low half, then a high half. Outgoing data changes at the start of the low half. The flash samples on the rising edge. Incoming nibbles are captured at the end of the low half.

A transaction runs through these states: `ST_IDLE` (deselected), `ST_OPC` (8 opcode clocks on line 0), `ST_ADR` (address nibbles), `ST_MOD` (mode byte), `ST_DMY` (dummy clocks, lines released), `ST_DAT` (data nibbles), then `ST_GAP` (deselect spacing), and back to `ST_IDLE`. A separate path `ST_IDLE -> ST_EXIT -> ST_GAP` sends an escape sequence. From `ST_IDLE` the block goes to `ST_OPC` when continuous mode is off, or straight to `ST_ADR` when it is on. The other transitions are: `ST_OPC -> ST_ADR` after 8 clocks, `ST_ADR -> ST_MOD` after 6, `ST_MOD -> ST_DMY` after 2, `ST_DMY -> ST_DAT` after 4, `ST_DAT -> ST_GAP` after the last byte, and `ST_GAP -> ST_IDLE` after the deselect time. A bad request gets an error pulse and the block stays in `ST_IDLE`.

The `stay_cont` input selects the mode byte. A0h keeps the flash in continuous-read mode, so the next read omits the opcode. 00h returns the flash to normal command decoding. A pulse on `exit_cont` clears continuous mode by sending all-ones on the lines for 8 clocks.

Top module: `qxr_flash_reader`

## Requirements
- R1: After reset `cs_n` is 1, `sck` is at `SCK_IDLE`, `io_oe` is 0000, `rd_valid` is 0, `cont_mode` is 0 and `req_ready` is 1.
- R2: When `cont_mode` is 0, a transaction begins with opcode EBh on `io_out[0]`, MSB first, one bit per serial clock for 8 clocks, with `io_oe` = 0001.
- R3: The address follows in 6 clocks and then the mode byte in 2 clocks. All four lines are driven (`io_oe` = 1111). The upper nibble goes first, and `io_out[3]` carries the most significant bit of each nibble.
- R4: 4 dummy clocks follow the mode byte. `io_oe` is 0000 from the first dummy clock until chip select rises.
- R5: Each byte takes 2 clocks, upper nibble first (`io_in[3]` is the MSB of the nibble). Bytes are delivered in ascending address order. A transaction of n bytes is 20+2n rising clock edges long.
- R6: With `stay_cont` = 1 the mode byte is A0h and `cont_mode` becomes 1. The following transaction omits the opcode and is 12+2n clocks long.
- R7: With `stay_cont` = 0 the mode byte is 00h, `cont_mode` becomes 0, and the following transaction includes the opcode.
- R8: A request with `quad_en` = 0 or `req_len` = 0 is accepted and gives a one-cycle `req_err` pulse. It causes no chip-select activity and leaves `cont_mode` unchanged.
- R9: An `exit_cont` pulse while `cont_mode` is 1 sends 8 clocks with `io_out` = 1111 and `io_oe` = 1111, clears `cont_mode`, and the next read carries the opcode. While `cont_mode` is 0 the pulse causes no bus activity.
- R10: While a returned byte waits unaccepted, `rd_data` holds steady and the serial clock stops. No byte is lost and the clock count is unchanged.
- R11: Chip select stays high for at least 2 system cycles between transactions.
- R12: While chip select is high, `sck` sits at `SCK_IDLE`, so the bus works in mode 0 (`SCK_IDLE` = 0) or mode 3 (`SCK_IDLE` = 1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Read request present |
| req_ready | output | 1 | Block can take a request |
| req_addr | input | ADDR_W | Start byte address |
| req_len | input | LEN_W | Number of bytes to read |
| req_err | output | 1 | One-cycle pulse: request refused |
| quad_en | input | 1 | Flash quad mode is enabled |
| stay_cont | input | 1 | 1: send A0h mode byte, 0: send 00h |
| exit_cont | input | 1 | Pulse: leave continuous-read mode |
| cont_mode | output | 1 | Next read skips the opcode |
| rd_data | output | 8 | Returned byte |
| rd_valid | output | 1 | Returned byte valid |
| rd_ready | input | 1 | Consumer takes the byte |
| cs_n | output | 1 | Flash chip select, active low |
| sck | output | 1 | Serial clock |
| io_out | output | 4 | Data driven to the four lines |
| io_oe | output | 4 | Per-line output enable |
| io_in | input | 4 | Data sampled from the four lines |

## Verification
If the continuous-mode flag holds the wrong value, the very next transaction shows it. It either carries 8 extra opcode clocks or is missing them, so a responder that tracks the mode byte sees a mismatched clock count or a garbled address within the first 8 serial clocks. A phase counter that is off by one moves the turnaround: the output enables are then still on when the responder starts driving, or the first nibble is captured one clock early, and the returned bytes come out shifted or swapped on the first byte. A fault in the hold logic shows when the consumer is slowed: a byte disappears from the stream or appears twice.

// File: rtl/qxr_pkg.sv
package qxr_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_OPC,
        ST_ADR,
        ST_MOD,
        ST_DMY,
        ST_DAT,
        ST_EXIT,
        ST_GAP
    } qxr_state_e;

    localparam logic [7:0] QXR_OPCODE     = 8'hEB;
    localparam logic [7:0] QXR_MODE_STAY  = 8'hA0;
    localparam logic [7:0] QXR_MODE_LEAVE = 8'h00;

endpackage

// File: rtl/qxr_tx_shift.sv
module qxr_tx_shift #(
    parameter int W = 40
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         sh1,
    input  logic         sh4,
    output logic         top1,
    output logic [3:0]   top4
);

    logic [W-1:0] sr_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sr_q <= '0;
        end else if (load) begin
            sr_q <= load_val;
        end else if (sh4) begin
            sr_q <= {sr_q[W-5:0], 4'h0};
        end else if (sh1) begin
            sr_q <= {sr_q[W-2:0], 1'b0};
        end
    end

    assign top1 = sr_q[W-1];
    assign top4 = sr_q[W-1:W-4];

endmodule

// File: rtl/qxr_rx_pack.sv
module qxr_rx_pack (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       smp,
    input  logic       upper,
    input  logic [3:0] nib_in,
    input  logic       out_ready,
    output logic [7:0] out_data,
    output logic       out_valid
);

    logic [3:0] hold_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_q    <= '0;
            out_data  <= '0;
            out_valid <= 1'b0;
        end else begin
            if (smp && upper) begin
                hold_q <= nib_in;
            end
            if (smp && !upper) begin
                out_data  <= {hold_q, nib_in};
                out_valid <= 1'b1;
            end else if (out_valid && out_ready) begin
                out_valid <= 1'b0;
            end
        end
    end

    // R10: a waiting byte stays put until taken
    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

    // R10: a completed byte never lands on one still waiting
    a_r10_no_overrun: assert property (@(posedge clk) disable iff (!rst_n)
        (smp && !upper) |-> !out_valid);

endmodule

// File: rtl/qxr_flash_reader.sv
module qxr_flash_reader
    import qxr_pkg::*;
#(
    parameter int   ADDR_W    = 24,
    parameter int   LEN_W     = 8,
    parameter int   DUMMY_CLK = 4,
    parameter int   GAP_CYC   = 2,
    parameter logic SCK_IDLE  = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [LEN_W-1:0]  req_len,
    output logic              req_err,
    input  logic              quad_en,
    input  logic              stay_cont,
    input  logic              exit_cont,
    output logic              cont_mode,
    output logic [7:0]        rd_data,
    output logic              rd_valid,
    input  logic              rd_ready,
    output logic              cs_n,
    output logic              sck,
    output logic [3:0]        io_out,
    output logic [3:0]        io_oe,
    input  logic [3:0]        io_in
);

    localparam int ADR_CLK = ADDR_W / 4;
    localparam int MOD_CLK = 2;
    localparam int OPC_CLK = 8;
    localparam int SH_W    = 8 + ADDR_W + 8;
    localparam int MAX_A   = (ADR_CLK > OPC_CLK) ? ADR_CLK : OPC_CLK;
    localparam int MAX_B   = (DUMMY_CLK > GAP_CYC) ? DUMMY_CLK : GAP_CYC;
    localparam int MAX_C   = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int CNT_W   = $clog2(MAX_C + 1);

    localparam logic [CNT_W-1:0] LAST_OPC = CNT_W'(OPC_CLK - 1);
    localparam logic [CNT_W-1:0] LAST_ADR = CNT_W'(ADR_CLK - 1);
    localparam logic [CNT_W-1:0] LAST_MOD = CNT_W'(MOD_CLK - 1);
    localparam logic [CNT_W-1:0] LAST_DMY = CNT_W'(DUMMY_CLK - 1);
    localparam logic [CNT_W-1:0] LAST_GAP = CNT_W'(GAP_CYC);

    qxr_state_e        state_q, state_d;
    logic              ph_q, ph_d;
    logic [CNT_W-1:0]  cnt_q, cnt_d;
    logic [LEN_W-1:0]  left_q, left_d;
    logic              nib_q, nib_d;
    logic              stay_q, stay_d;
    logic              cont_q, cont_d;
    logic              pend_q, pend_d;
    logic              err_q, err_d;

    logic              tx_load, tx_sh1, tx_sh4, tx_top1;
    logic [SH_W-1:0]   tx_val;
    logic [3:0]        tx_top4;
    logic              smp, stall;
    logic [7:0]        mode_b;

    assign mode_b = stay_cont ? QXR_MODE_STAY : QXR_MODE_LEAVE;
    assign stall  = (state_q == ST_DAT) && !ph_q && !nib_q && rd_valid && !rd_ready;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            ph_q    <= 1'b0;
            cnt_q   <= '0;
            left_q  <= '0;
            nib_q   <= 1'b0;
            stay_q  <= 1'b0;
            cont_q  <= 1'b0;
            pend_q  <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            ph_q    <= ph_d;
            cnt_q   <= cnt_d;
            left_q  <= left_d;
            nib_q   <= nib_d;
            stay_q  <= stay_d;
            cont_q  <= cont_d;
            pend_q  <= pend_d;
            err_q   <= err_d;
        end
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        ph_d    = ph_q;
        cnt_d   = cnt_q;
        left_d  = left_q;
        nib_d   = nib_q;
        stay_d  = stay_q;
        cont_d  = cont_q;
        pend_d  = pend_q | exit_cont;
        err_d   = 1'b0;
        tx_load = 1'b0;
        tx_val  = '0;
        tx_sh1  = 1'b0;
        tx_sh4  = 1'b0;
        smp     = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                ph_d  = 1'b0;
                cnt_d = '0;
                if (pend_q) begin
                    pend_d = exit_cont;
                    if (cont_q) begin
                        state_d = ST_EXIT;
                        tx_load = 1'b1;
                        tx_val  = '1;
                    end
                end else if (req_valid) begin
                    if (!quad_en || req_len == '0) begin
                        err_d = 1'b1;
                    end else begin
                        state_d = cont_q ? ST_ADR : ST_OPC;
                        tx_load = 1'b1;
                        tx_val  = cont_q ? {req_addr, mode_b, 8'h00}
                                         : {QXR_OPCODE, req_addr, mode_b};
                        left_d  = req_len;
                        nib_d   = 1'b0;
                        stay_d  = stay_cont;
                    end
                end
            end
            ST_OPC: begin
                ph_d = !ph_q;
                if (ph_q) begin
                    tx_sh1 = 1'b1;
                    cnt_d  = cnt_q + 1'b1;
                    if (cnt_q == LAST_OPC) begin
                        state_d = ST_ADR;
                        cnt_d   = '0;
                    end
                end
            end
            ST_ADR: begin
                ph_d = !ph_q;
                if (ph_q) begin
                    tx_sh4 = 1'b1;
                    cnt_d  = cnt_q + 1'b1;
                    if (cnt_q == LAST_ADR) begin
                        state_d = ST_MOD;
                        cnt_d   = '0;
                    end
                end
            end
            ST_MOD: begin
                ph_d = !ph_q;
                if (ph_q) begin
                    tx_sh4 = 1'b1;
                    cnt_d  = cnt_q + 1'b1;
                    if (cnt_q == LAST_MOD) begin
                        state_d = ST_DMY;
                        cnt_d   = '0;
                        cont_d  = stay_q;
                    end
                end
            end
            ST_DMY: begin
                ph_d = !ph_q;
                if (ph_q) begin
                    cnt_d = cnt_q + 1'b1;
                    if (cnt_q == LAST_DMY) begin
                        state_d = ST_DAT;
                        cnt_d   = '0;
                    end
                end
            end
            ST_DAT: begin
                if (!stall) begin
                    ph_d = !ph_q;
                    if (!ph_q) begin
                        smp = 1'b1;
                    end else begin
                        nib_d = !nib_q;
                        if (nib_q) begin
                            left_d = left_q - 1'b1;
                            if (left_q == LEN_W'(1)) begin
                                state_d = ST_GAP;
                                cnt_d   = '0;
                            end
                        end
                    end
                end
            end
            ST_EXIT: begin
                ph_d = !ph_q;
                if (ph_q) begin
                    cnt_d = cnt_q + 1'b1;
                    if (cnt_q == LAST_OPC) begin
                        state_d = ST_GAP;
                        cnt_d   = '0;
                        cont_d  = 1'b0;
                    end
                end
            end
            ST_GAP: begin
                ph_d  = 1'b0;
                cnt_d = cnt_q + 1'b1;
                if (cnt_q == LAST_GAP) begin
                    state_d = ST_IDLE;
                    cnt_d   = '0;
                end
            end
        endcase
    end

    // output logic
    always_comb begin
        cs_n   = 1'b0;
        sck    = ph_q;
        io_out = 4'h0;
        io_oe  = 4'h0;
        unique case (state_q)
            ST_IDLE: begin
                cs_n = 1'b1;
                sck  = SCK_IDLE;
            end
            ST_GAP: begin
                cs_n = (cnt_q != '0);
                sck  = SCK_IDLE;
            end
            ST_OPC: begin
                io_out = {3'b000, tx_top1};
                io_oe  = 4'b0001;
            end
            ST_ADR, ST_MOD, ST_EXIT: begin
                io_out = tx_top4;
                io_oe  = 4'b1111;
            end
            ST_DMY, ST_DAT: begin
                io_out = 4'h0;
                io_oe  = 4'h0;
            end
        endcase
    end

    assign req_ready = (state_q == ST_IDLE) && !pend_q;
    assign req_err   = err_q;
    assign cont_mode = cont_q;

    qxr_tx_shift #(.W(SH_W)) u_tx (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tx_load),
        .load_val (tx_val),
        .sh1      (tx_sh1),
        .sh4      (tx_sh4),
        .top1     (tx_top1),
        .top4     (tx_top4)
    );

    qxr_rx_pack u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .smp       (smp),
        .upper     (!nib_q),
        .nib_in    (io_in),
        .out_ready (rd_ready),
        .out_data  (rd_data),
        .out_valid (rd_valid)
    );

    // R4: lines were already released in the cycle before data begins
    a_r4_float_before_data: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DAT && $past(state_q) != ST_DAT) |-> ($past(io_oe) == 4'h0));

    // R11: chip select stays high for a second cycle once raised
    a_r11_gap: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cs_n) |=> cs_n);

    // R12: deselected bus keeps the idle clock level
    a_r12_idle_clk: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n && $past(cs_n)) |-> (sck == SCK_IDLE));

    // R6: skipping the opcode only happens in continuous mode
    a_r6_skip_only_cont: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ADR && $past(state_q) == ST_IDLE) |-> cont_q);

    // R8: a refused request leaves the bus deselected
    a_r8_err_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        req_err |-> cs_n);

    // R9: continuous mode is clear once the escape sequence finishes
    a_r9_exit_clears: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state_q) == ST_EXIT && state_q == ST_GAP) |-> !cont_q);

endmodule

// File: tb/sim_qxr_flash_reader.sv
module sim_qxr_flash_reader;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [23:0] req_addr = '0;
    logic [7:0]  req_len = '0;
    logic        req_err;
    logic        quad_en = 1'b1;
    logic        stay_cont = 1'b0;
    logic        exit_cont = 1'b0;
    logic        cont_mode;
    logic [7:0]  rd_data;
    logic        rd_valid;
    logic        rd_ready;
    logic        cs_n, sck;
    logic [3:0]  io_out, io_oe, io_in;

    qxr_flash_reader u0 (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_len(req_len), .req_err(req_err),
        .quad_en(quad_en), .stay_cont(stay_cont), .exit_cont(exit_cont),
        .cont_mode(cont_mode),
        .rd_data(rd_data), .rd_valid(rd_valid), .rd_ready(rd_ready),
        .cs_n(cs_n), .sck(sck), .io_out(io_out), .io_oe(io_oe), .io_in(io_in)
    );

    int checks = 0;
    int fails  = 0;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] dbyte(input logic [23:0] a);
        return a[7:0] ^ a[15:8] ^ {a[19:16], a[23:20]} ^ 8'h3C;
    endfunction

    // behavioural quad flash responder
    logic [3:0]  fl_drv = 4'h0;
    logic        fl_oe  = 1'b0;
    assign io_in = fl_oe ? fl_drv : 4'h0;

    int          r_cnt = 0;
    logic        r_cont = 1'b0;
    logic        r_hasopc = 1'b1;
    logic [7:0]  r_opc = '0;
    logic [23:0] r_addr = '0;
    logic [7:0]  r_mode = '0;
    logic        r_mdone = 1'b0;
    int          last_clks = 0;
    logic        last_hasopc = 1'b0;
    logic [7:0]  last_opc = '0;
    logic [23:0] last_addr = '0;
    logic [7:0]  last_mode = '0;
    int          txn_n = 0;
    int          oe_bad = 0;
    int          clash = 0;

    always @(negedge cs_n) begin
        r_cnt = 0; r_hasopc = !r_cont; r_opc = '0; r_addr = '0; r_mode = '0; r_mdone = 1'b0;
    end

    always @(posedge sck) begin
        int b;
        if (cs_n === 1'b0) begin
            r_cnt++;
            b = r_hasopc ? 8 : 0;
            if (r_hasopc && r_cnt <= 8) begin
                r_opc = {r_opc[6:0], io_out[0]};
                if (io_oe !== 4'b0001) oe_bad++;
            end else if (r_cnt <= b + 6) begin
                r_addr = {r_addr[19:0], io_out};
                if (io_oe !== 4'hF) oe_bad++;
            end else if (r_cnt <= b + 8) begin
                r_mode = {r_mode[3:0], io_out};
                if (io_oe !== 4'hF) oe_bad++;
                if (r_cnt == b + 8) r_mdone = 1'b1;
            end
        end
    end

    always @(negedge sck) begin
        int h, idx;
        logic [7:0] d;
        if (cs_n === 1'b0 && r_mdone) begin
            h = (r_hasopc ? 8 : 0) + 12;
            if (r_cnt >= h) begin
                idx = r_cnt - h;
                d = dbyte(r_addr + 24'(idx / 2));
                fl_drv = (idx % 2 == 0) ? d[7:4] : d[3:0];
                fl_oe = 1'b1;
            end
        end
    end

    always @(posedge cs_n) begin
        if (rst_n === 1'b1) begin
            fl_oe = 1'b0;
            if (r_mdone) r_cont = (r_mode[7:4] == 4'hA);
            last_clks = r_cnt; last_hasopc = r_hasopc; last_opc = r_opc;
            last_addr = r_addr; last_mode = r_mode;
            txn_n++;
        end
    end

    // byte collector and consumer pacing
    logic [7:0] rx_buf [32];
    int  rx_n = 0;
    int  cyc = 0;
    bit  slow = 1'b0;
    always @(negedge clk) begin
        cyc++;
        rd_ready = slow ? (cyc % 4 == 0) : 1'b1;
        if (rd_valid === 1'b1 && rd_ready) begin
            if (rx_n < 32) rx_buf[rx_n] = rd_data;
            rx_n++;
        end
        if (fl_oe && io_oe != 4'h0) clash++;
    end

    // watchdog
    always @(posedge clk) begin
        if (cyc > 150000) begin
            checks++; fails++;
            $display("FAIL watchdog actual=%0d expected=<150000", cyc);
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    task automatic wait_idle();
        @(negedge clk);
        while (!(req_ready && !rd_valid)) @(negedge clk);
    endtask

    task automatic issue(input logic [23:0] a, input logic [7:0] n, input logic keep);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_addr = a; req_len = n; stay_cont = keep; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    // fields: addr[33:10] len[9:2] keep[1] slow[0]
    localparam int NV = 6;
    localparam logic [33:0] VEC [NV] = '{
        {24'h000000, 8'd4, 1'b0, 1'b0},
        {24'h123456, 8'd3, 1'b1, 1'b0},
        {24'hABCDEF, 8'd5, 1'b1, 1'b0},
        {24'hFFFFFE, 8'd4, 1'b0, 1'b1},
        {24'h00FF00, 8'd1, 1'b0, 1'b0},
        {24'h7A5A5A, 8'd2, 1'b1, 1'b1}
    };

    initial begin
        logic exp_cont;
        int t0, mism, n0;
        exp_cont = 1'b0;

        // R1: reset state
        repeat (3) @(negedge clk);
        chk(cs_n == 1'b1, "R1 cs_n", 32'(cs_n), 1);
        chk(sck == 1'b0, "R1 sck idle", 32'(sck), 0);
        chk(io_oe == 4'h0, "R1 io_oe", 32'(io_oe), 0);
        chk(rd_valid == 1'b0, "R1 rd_valid", 32'(rd_valid), 0);
        chk(cont_mode == 1'b0, "R1 cont_mode", 32'(cont_mode), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready == 1'b1, "R1 req_ready", 32'(req_ready), 1);

        for (int v = 0; v < NV; v++) begin
            logic [23:0] a; logic [7:0] n; logic k;
            a = VEC[v][33:10]; n = VEC[v][9:2]; k = VEC[v][1];
            slow = VEC[v][0];
            rx_n = 0; t0 = txn_n; oe_bad = 0; clash = 0;
            issue(a, n, k);
            while (txn_n == t0) @(negedge clk);
            wait_idle();
            // R2/R6/R7 opcode presence follows the expected mode state
            chk(last_hasopc == !exp_cont, "R6 R7 opcode presence", 32'(last_hasopc), 32'(!exp_cont));
            if (!exp_cont) chk(last_opc == 8'hEB, "R2 opcode value", 32'(last_opc), 32'hEB);
            chk(last_addr == a, "R3 address", 32'(last_addr), 32'(a));
            chk(last_mode == (k ? 8'hA0 : 8'h00), "R3 R6 mode byte", 32'(last_mode), k ? 32'hA0 : 32'h0);
            chk(last_clks == (exp_cont ? 12 : 20) + 2 * int'(n), "R5 R10 clock count",
                32'(last_clks), 32'((exp_cont ? 12 : 20) + 2 * int'(n)));
            chk(oe_bad == 0, "R2 R3 lane enables", 32'(oe_bad), 0);
            chk(clash == 0, "R4 turnaround", 32'(clash), 0);
            chk(rx_n == int'(n), "R5 R10 byte count", 32'(rx_n), 32'(n));
            mism = 0;
            for (int i = 0; i < int'(n) && i < rx_n; i++)
                if (rx_buf[i] !== dbyte(a + 24'(i))) mism++;
            chk(mism == 0, "R5 byte order/value", 32'(mism), 0);
            chk(cont_mode == k, "R6 R7 cont_mode", 32'(cont_mode), 32'(k));
            exp_cont = k;
        end
        slow = 1'b0;

        // R8: refused requests
        t0 = txn_n;
        quad_en = 1'b0;
        @(negedge clk);
        req_addr = 24'h000100; req_len = 8'd2; req_valid = 1'b1;
        @(negedge clk);
        chk(req_err == 1'b1, "R8 err on quad_en low", 32'(req_err), 1);
        req_valid = 1'b0;
        quad_en = 1'b1;
        @(negedge clk);
        chk(req_err == 1'b0, "R8 err one cycle", 32'(req_err), 0);
        req_len = 8'd0; req_valid = 1'b1;
        @(negedge clk);
        chk(req_err == 1'b1, "R8 err on zero length", 32'(req_err), 1);
        req_valid = 1'b0;
        repeat (4) @(negedge clk);
        chk(txn_n == t0, "R8 no bus activity", 32'(txn_n), 32'(t0));
        chk(cont_mode == 1'b1, "R8 cont_mode kept", 32'(cont_mode), 1);

        // R9: escape sequence while in continuous mode
        t0 = txn_n;
        exit_cont = 1'b1;
        @(negedge clk);
        exit_cont = 1'b0;
        while (txn_n == t0) @(negedge clk);
        wait_idle();
        chk(last_clks == 8, "R9 exit clocks", 32'(last_clks), 8);
        chk(last_mode == 8'hFF && last_addr == 24'hFFFFFF, "R9 all ones", 32'(last_mode), 32'hFF);
        chk(cont_mode == 1'b0, "R9 cont_mode cleared", 32'(cont_mode), 0);
        t0 = txn_n; rx_n = 0;
        issue(24'h000040, 8'd2, 1'b0);
        while (txn_n == t0) @(negedge clk);
        wait_idle();
        chk(last_hasopc == 1'b1 && last_opc == 8'hEB, "R9 opcode after exit", 32'(last_opc), 32'hEB);
        chk(last_clks == 24, "R9 clock count after exit", 32'(last_clks), 24);

        // R9: exit pulse with continuous mode off does nothing
        t0 = txn_n;
        exit_cont = 1'b1;
        @(negedge clk);
        exit_cont = 1'b0;
        n0 = 0;
        repeat (30) begin
            @(negedge clk);
            if (cs_n !== 1'b1) n0++;
        end
        chk(n0 == 0 && txn_n == t0, "R9 no sequence when not continuous", 32'(n0), 0);

        // R11/R12: back-to-back requests keep a deselect gap at idle level
        t0 = txn_n;
        issue(24'h000200, 8'd1, 1'b0);
        issue(24'h000300, 8'd1, 1'b0);
        while (txn_n < t0 + 2) @(negedge clk);
        wait_idle();
        chk(txn_n == t0 + 2, "R11 two separate selects", 32'(txn_n), 32'(t0 + 2));
        chk(sck == 1'b0, "R12 idle clock level", 32'(sck), 0);

        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule